// File: doc/BRIEF.md
# Microcontroller Parallel Port Unit

This block holds the output latches for the parallel I/O of a small 4-bit microcontroller and forms the value the CPU sees when it reads a port. There are eight 4-bit nibble ports and sixteen single-bit lines. The CPU side writes through strobes that carry an index and data. Reads are combinational: the read index selects a value in the same cycle. The pin side gets every latch as an output bus and delivers the external pin levels back.

Two parameters fix the build. `IS_CMOS` picks how a read combines the pins with the latch: AND for the CMOS style, OR for the older style. `VARIANT` picks one of three chip variants, and the variant decides which nibble ports exist, which can be written and which lines are output-only. An access that a variant does not support raises a one-cycle error pulse. The pulse reports the index, whether the access was a write, and whether it was a line or a nibble port.

Top module: `mcuPortUnit`

## Requirements
- R1: A synchronous active-high reset sets every nibble latch to 4'hF and every line latch bit to 1. The error pulse is low in the cycle after reset.
- R2: A nibble write stores only the low 4 bits of the write data. It uses only the low 3 bits of the index. The stored value appears on that port's slice of `rPinOut` (bits index*4+3 down to index*4) after the clock edge that takes the write. A port that gets no accepted write holds its value.
- R3: A nibble read returns its value in the same cycle. With `IS_CMOS`=1 the value is the AND of the port's input and latch. With `IS_CMOS`=0 it is the OR of the two.
- R4: A nibble port whose `rPinDriven` bit is 0 reads its input as 4'hF before the merge.
- R5: A line write uses only the low 4 bits of the index. It sets or clears exactly that bit of the 16-bit line latch, and `dPinOut` shows the whole latch after the edge.
- R6: A line read returns, in the same cycle, the indexed bit of the pin input merged with the latch (AND for CMOS, OR otherwise).
- R7: In variant 0 (small), writes succeed only for indices 1 to 3. Writes to 0 and 4 to 7 change no latch. Reads of indices 2 to 7 are errors. Lines 4 to 15 are output-only: a read of one returns the latch bit alone and is an error.
- R8: In variant 1 (middle), indices 0 to 5 are writable, and 4 and 5 act as plain storage that reads back without error. Writes to 6 and 7 are ignored, and reads of 6 and 7 are errors. All sixteen lines are bidirectional.
- R9: In variant 2 (large), only writes to index 7 are ignored. Reads of indices 6 and 7 are errors. All lines are bidirectional.
- R10: One cycle after an unsupported access, `accErr` is high for one cycle. `accErrIdx` carries the truncated index, `accErrWrite` is 1 for a write, and `accErrOnD` is 1 for a line access. When several unsupported accesses fall in one cycle, the reported one is chosen in this order: nibble write, then nibble read, then line read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rWrEn | input | 1 | Nibble port write strobe |
| rWrIdx | input | IDX_IN_W | Nibble write index (low 3 bits used) |
| rWrData | input | WDATA_W | Nibble write data (low 4 bits used) |
| rRdEn | input | 1 | Nibble read strobe (error reporting only) |
| rRdIdx | input | IDX_IN_W | Nibble read index |
| rRdData | output | 4 | Merged nibble read value |
| dWrEn | input | 1 | Line write strobe |
| dWrIdx | input | IDX_IN_W | Line write index (low 4 bits used) |
| dWrVal | input | 1 | Line write value |
| dRdEn | input | 1 | Line read strobe (error reporting only) |
| dRdIdx | input | IDX_IN_W | Line read index |
| dRdBit | output | 1 | Merged line read value |
| rPinIn | input | 32 | External nibble inputs, port p at bits 4p+3:4p |
| rPinDriven | input | 8 | Per-port flag: external input present |
| dPinIn | input | 16 | External line inputs |
| rPinOut | output | 32 | Nibble latches, port p at bits 4p+3:4p |
| dPinOut | output | 16 | Line latch |
| accErr | output | 1 | Unsupported-access pulse |
| accErrIdx | output | 4 | Index of the reported access |
| accErrWrite | output | 1 | Reported access was a write |
| accErrOnD | output | 1 | Reported access was a line access |

## Verification
The assertions check four things on every cycle. The nibble latches change only under a write strobe, and port 0 of the small variant stays frozen. A line write flips at most one latch bit. A nibble read never shows a bit that the merge rule forbids relative to the selected latch. The bench's scenarios are needed for the rest: the exact read values under undriven and driven inputs, the per-variant accept/ignore maps, latch-only reads of output-only lines, index truncation, and the contents and priority of the error report. Three instances (small CMOS, middle OR-style, large CMOS) run against a bench model under shared random and directed traffic.

// File: rtl/mcuPortPkg.sv
package mcuPortPkg;
  localparam int R_PORTS   = 8;
  localparam int R_W       = 4;
  localparam int D_LINES   = 16;
  localparam int R_SEL_W   = $clog2(R_PORTS);
  localparam int D_SEL_W   = $clog2(D_LINES);
  localparam int ERR_IDX_W = (R_SEL_W > D_SEL_W) ? R_SEL_W : D_SEL_W;

  typedef enum logic [1:0] {
    VAR_SMALL = 2'd0,
    VAR_MID   = 2'd1,
    VAR_LARGE = 2'd2
  } chipVariantT;

  // Strobes and selects from control to datapath
  typedef struct packed {
    logic               rLoad;
    logic [R_SEL_W-1:0] rWrSel;
    logic [R_SEL_W-1:0] rRdSel;
    logic               dLoad;
    logic [D_SEL_W-1:0] dWrSel;
    logic [D_SEL_W-1:0] dRdSel;
    logic               dRdLatchOnly;
  } portStrobeT;

  function automatic logic rWriteOk(chipVariantT v, logic [R_SEL_W-1:0] idx);
    case (v)
      VAR_SMALL: rWriteOk = (idx >= R_SEL_W'(1)) && (idx <= R_SEL_W'(3));
      VAR_MID:   rWriteOk = (idx <= R_SEL_W'(5));
      default:   rWriteOk = (idx != R_SEL_W'(7));
    endcase
  endfunction

  function automatic logic rReadBad(chipVariantT v, logic [R_SEL_W-1:0] idx);
    case (v)
      VAR_SMALL: rReadBad = (idx >= R_SEL_W'(2));
      default:   rReadBad = (idx >= R_SEL_W'(6));
    endcase
  endfunction

  function automatic logic dOutputOnly(chipVariantT v, logic [D_SEL_W-1:0] idx);
    dOutputOnly = (v == VAR_SMALL) && (idx >= D_SEL_W'(4));
  endfunction
endpackage

// File: rtl/portCtrl.sv
module portCtrl
  import mcuPortPkg::*;
#(
  parameter chipVariantT VARIANT  = VAR_SMALL,
  parameter int          IDX_IN_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rWrEn,
  input  logic [IDX_IN_W-1:0]  rWrIdx,
  input  logic                 rRdEn,
  input  logic [IDX_IN_W-1:0]  rRdIdx,
  input  logic                 dWrEn,
  input  logic [IDX_IN_W-1:0]  dWrIdx,
  input  logic                 dRdEn,
  input  logic [IDX_IN_W-1:0]  dRdIdx,
  output portStrobeT           stb,
  output logic                 accErr,
  output logic [ERR_IDX_W-1:0] accErrIdx,
  output logic                 accErrWrite,
  output logic                 accErrOnD
);
  logic [R_SEL_W-1:0] rWrSel, rRdSel;
  logic [D_SEL_W-1:0] dWrSel, dRdSel;
  logic wrBad, rdBad, dBad;
  logic errNext, errWrNext, errOnDNext;
  logic [ERR_IDX_W-1:0] errIdxNext;
  logic unusedIdxBits;

  // Index truncation onto the defined ports
  assign rWrSel = rWrIdx[R_SEL_W-1:0];
  assign rRdSel = rRdIdx[R_SEL_W-1:0];
  assign dWrSel = dWrIdx[D_SEL_W-1:0];
  assign dRdSel = dRdIdx[D_SEL_W-1:0];
  assign unusedIdxBits = ^{rWrIdx[IDX_IN_W-1:R_SEL_W], rRdIdx[IDX_IN_W-1:R_SEL_W],
                           dWrIdx[IDX_IN_W-1:D_SEL_W], dRdIdx[IDX_IN_W-1:D_SEL_W]};

  assign wrBad = rWrEn && !rWriteOk(VARIANT, rWrSel);
  assign rdBad = rRdEn && rReadBad(VARIANT, rRdSel);
  assign dBad  = dRdEn && dOutputOnly(VARIANT, dRdSel);

  always_comb begin
    stb.rLoad        = rWrEn && !wrBad;
    stb.rWrSel       = rWrSel;
    stb.rRdSel       = rRdSel;
    stb.dLoad        = dWrEn;
    stb.dWrSel       = dWrSel;
    stb.dRdSel       = dRdSel;
    stb.dRdLatchOnly = dOutputOnly(VARIANT, dRdSel);
  end

  // Error source priority: nibble write, nibble read, line read
  always_comb begin
    errNext    = wrBad || rdBad || dBad;
    errWrNext  = wrBad;
    errOnDNext = !wrBad && !rdBad && dBad;
    if (wrBad)      errIdxNext = ERR_IDX_W'(rWrSel);
    else if (rdBad) errIdxNext = ERR_IDX_W'(rRdSel);
    else if (dBad)  errIdxNext = ERR_IDX_W'(dRdSel);
    else            errIdxNext = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accErr      <= 1'b0;
      accErrIdx   <= '0;
      accErrWrite <= 1'b0;
      accErrOnD   <= 1'b0;
    end else begin
      accErr      <= errNext;
      accErrIdx   <= errIdxNext;
      accErrWrite <= errWrNext;
      accErrOnD   <= errOnDNext;
    end
  end
endmodule

// File: rtl/portData.sv
module portData
  import mcuPortPkg::*;
#(
  parameter bit IS_CMOS = 1'b1,
  parameter int WDATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  portStrobeT             stb,
  input  logic [WDATA_W-1:0]     rWrData,
  input  logic                   dWrVal,
  input  logic [R_PORTS*R_W-1:0] rPinIn,
  input  logic [R_PORTS-1:0]     rPinDriven,
  input  logic [D_LINES-1:0]     dPinIn,
  output logic [R_PORTS*R_W-1:0] rPinOut,
  output logic [D_LINES-1:0]     dPinOut,
  output logic [R_W-1:0]         rRdData,
  output logic                   dRdBit
);
  logic [R_W-1:0]     rLatch  [R_PORTS];
  logic [R_W-1:0]     rMerged [R_PORTS];
  logic [D_LINES-1:0] dLatch, dMerged;
  logic               unusedDataBits;

  assign unusedDataBits = ^rWrData[WDATA_W-1:R_W];

  for (genvar p = 0; p < R_PORTS; p++) begin : gNibble
    logic [R_W-1:0] effIn;
    always_ff @(posedge clk) begin
      if (rst) rLatch[p] <= '1;
      else if (stb.rLoad && stb.rWrSel == R_SEL_W'(p)) rLatch[p] <= rWrData[R_W-1:0];
    end
    assign effIn = rPinDriven[p] ? rPinIn[p*R_W +: R_W] : '1;
    if (IS_CMOS) begin : gAnd
      assign rMerged[p] = effIn & rLatch[p];
    end else begin : gOr
      assign rMerged[p] = effIn | rLatch[p];
    end
    assign rPinOut[p*R_W +: R_W] = rLatch[p];
  end

  always_ff @(posedge clk) begin
    if (rst) dLatch <= '1;
    else if (stb.dLoad) dLatch[stb.dWrSel] <= dWrVal;
  end

  if (IS_CMOS) begin : gDAnd
    assign dMerged = dPinIn & dLatch;
  end else begin : gDOr
    assign dMerged = dPinIn | dLatch;
  end

  assign dPinOut = dLatch;
  assign rRdData = rMerged[stb.rRdSel];
  assign dRdBit  = stb.dRdLatchOnly ? dLatch[stb.dRdSel] : dMerged[stb.dRdSel];
endmodule

// File: rtl/mcuPortUnit.sv
module mcuPortUnit
  import mcuPortPkg::*;
#(
  parameter bit          IS_CMOS  = 1'b1,
  parameter chipVariantT VARIANT  = VAR_SMALL,
  parameter int          IDX_IN_W = 8,
  parameter int          WDATA_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rWrEn,
  input  logic [IDX_IN_W-1:0]    rWrIdx,
  input  logic [WDATA_W-1:0]     rWrData,
  input  logic                   rRdEn,
  input  logic [IDX_IN_W-1:0]    rRdIdx,
  output logic [R_W-1:0]         rRdData,
  input  logic                   dWrEn,
  input  logic [IDX_IN_W-1:0]    dWrIdx,
  input  logic                   dWrVal,
  input  logic                   dRdEn,
  input  logic [IDX_IN_W-1:0]    dRdIdx,
  output logic                   dRdBit,
  input  logic [R_PORTS*R_W-1:0] rPinIn,
  input  logic [R_PORTS-1:0]     rPinDriven,
  input  logic [D_LINES-1:0]     dPinIn,
  output logic [R_PORTS*R_W-1:0] rPinOut,
  output logic [D_LINES-1:0]     dPinOut,
  output logic                   accErr,
  output logic [ERR_IDX_W-1:0]   accErrIdx,
  output logic                   accErrWrite,
  output logic                   accErrOnD
);
  portStrobeT stb;

  portCtrl #(.VARIANT(VARIANT), .IDX_IN_W(IDX_IN_W)) uCtrl (
    .clk(clk), .rst(rst),
    .rWrEn(rWrEn), .rWrIdx(rWrIdx), .rRdEn(rRdEn), .rRdIdx(rRdIdx),
    .dWrEn(dWrEn), .dWrIdx(dWrIdx), .dRdEn(dRdEn), .dRdIdx(dRdIdx),
    .stb(stb), .accErr(accErr), .accErrIdx(accErrIdx),
    .accErrWrite(accErrWrite), .accErrOnD(accErrOnD)
  );

  portData #(.IS_CMOS(IS_CMOS), .WDATA_W(WDATA_W)) uData (
    .clk(clk), .rst(rst), .stb(stb), .rWrData(rWrData), .dWrVal(dWrVal),
    .rPinIn(rPinIn), .rPinDriven(rPinDriven), .dPinIn(dPinIn),
    .rPinOut(rPinOut), .dPinOut(dPinOut), .rRdData(rRdData), .dRdBit(dRdBit)
  );
endmodule

// File: rtl/mcuPortChk.sv
module mcuPortChk
  import mcuPortPkg::*;
#(
  parameter bit          IS_CMOS  = 1'b1,
  parameter chipVariantT VARIANT  = VAR_SMALL,
  parameter int          IDX_IN_W = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   rWrEn,
  input logic [IDX_IN_W-1:0]    rWrIdx,
  input logic                   rRdEn,
  input logic [IDX_IN_W-1:0]    rRdIdx,
  input logic [R_W-1:0]         rRdData,
  input logic                   dWrEn,
  input logic                   dRdEn,
  input logic [R_PORTS*R_W-1:0] rPinOut,
  input logic [D_LINES-1:0]     dPinOut,
  input logic                   accErr
);
  logic [R_W-1:0] selLatch;
  assign selLatch = rPinOut[rRdIdx[R_SEL_W-1:0]*R_W +: R_W];

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!accErr && (&rPinOut) && (&dPinOut)));

  // R2
  nibble_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rWrEn |=> $stable(rPinOut));

  // R5
  line_single_bit_chk: assert property (@(posedge clk) disable iff (rst)
    dWrEn |=> ($countones(dPinOut ^ $past(dPinOut)) <= 1));

  // R5
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dWrEn |=> $stable(dPinOut));

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    accErr |-> $past(rWrEn || rRdEn || dRdEn));

  // R3
  if (IS_CMOS) begin : gAndChk
    merge_and_chk: assert property (@(posedge clk) disable iff (rst)
      (rRdData & ~selLatch) == '0);
  end else begin : gOrChk
    merge_or_chk: assert property (@(posedge clk) disable iff (rst)
      (selLatch & ~rRdData) == '0);
  end

  // R7
  if (VARIANT == VAR_SMALL) begin : gSmallChk
    small_input_only_chk: assert property (@(posedge clk) disable iff (rst)
      (rWrEn && rWrIdx[R_SEL_W-1:0] == '0) |=> $stable(rPinOut[R_W-1:0]));
  end
endmodule

bind mcuPortUnit mcuPortChk #(.IS_CMOS(IS_CMOS), .VARIANT(VARIANT), .IDX_IN_W(IDX_IN_W)) uChk (
  .clk(clk), .rst(rst), .rWrEn(rWrEn), .rWrIdx(rWrIdx), .rRdEn(rRdEn), .rRdIdx(rRdIdx),
  .rRdData(rRdData), .dWrEn(dWrEn), .dRdEn(dRdEn), .rPinOut(rPinOut),
  .dPinOut(dPinOut), .accErr(accErr)
);

// File: tb/tb_mcuPortUnit.sv
`timescale 1ns/100ps
module tb_mcuPortUnit;
  import mcuPortPkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        rWrEn = 0, rRdEn = 0, dWrEn = 0, dRdEn = 0, dWrVal = 0;
  logic [7:0]  rWrIdx = 0, rWrData = 0, rRdIdx = 0, dWrIdx = 0, dRdIdx = 0;
  logic [31:0] rPinIn = 0;
  logic [7:0]  rPinDriven = 0;
  logic [15:0] dPinIn = 0;

  logic [31:0] rPO [3];
  logic [15:0] dPO [3];
  logic [3:0]  rRD [3];
  logic        dRB [3];
  logic        ae  [3];
  logic [3:0]  aeI [3];
  logic        aeW [3];
  logic        aeD [3];

  mcuPortUnit #(.IS_CMOS(1'b1), .VARIANT(VAR_SMALL)) dut (
    .clk(clk), .rst(rst), .rWrEn(rWrEn), .rWrIdx(rWrIdx), .rWrData(rWrData),
    .rRdEn(rRdEn), .rRdIdx(rRdIdx), .rRdData(rRD[0]), .dWrEn(dWrEn), .dWrIdx(dWrIdx),
    .dWrVal(dWrVal), .dRdEn(dRdEn), .dRdIdx(dRdIdx), .dRdBit(dRB[0]), .rPinIn(rPinIn),
    .rPinDriven(rPinDriven), .dPinIn(dPinIn), .rPinOut(rPO[0]), .dPinOut(dPO[0]),
    .accErr(ae[0]), .accErrIdx(aeI[0]), .accErrWrite(aeW[0]), .accErrOnD(aeD[0]));

  mcuPortUnit #(.IS_CMOS(1'b0), .VARIANT(VAR_MID)) dutMid (
    .clk(clk), .rst(rst), .rWrEn(rWrEn), .rWrIdx(rWrIdx), .rWrData(rWrData),
    .rRdEn(rRdEn), .rRdIdx(rRdIdx), .rRdData(rRD[1]), .dWrEn(dWrEn), .dWrIdx(dWrIdx),
    .dWrVal(dWrVal), .dRdEn(dRdEn), .dRdIdx(dRdIdx), .dRdBit(dRB[1]), .rPinIn(rPinIn),
    .rPinDriven(rPinDriven), .dPinIn(dPinIn), .rPinOut(rPO[1]), .dPinOut(dPO[1]),
    .accErr(ae[1]), .accErrIdx(aeI[1]), .accErrWrite(aeW[1]), .accErrOnD(aeD[1]));

  mcuPortUnit #(.IS_CMOS(1'b1), .VARIANT(VAR_LARGE)) dutLarge (
    .clk(clk), .rst(rst), .rWrEn(rWrEn), .rWrIdx(rWrIdx), .rWrData(rWrData),
    .rRdEn(rRdEn), .rRdIdx(rRdIdx), .rRdData(rRD[2]), .dWrEn(dWrEn), .dWrIdx(dWrIdx),
    .dWrVal(dWrVal), .dRdEn(dRdEn), .dRdIdx(dRdIdx), .dRdBit(dRB[2]), .rPinIn(rPinIn),
    .rPinDriven(rPinDriven), .dPinIn(dPinIn), .rPinOut(rPO[2]), .dPinOut(dPO[2]),
    .accErr(ae[2]), .accErrIdx(aeI[2]), .accErrWrite(aeW[2]), .accErrOnD(aeD[2]));

  int checks = 0, errors = 0;
  bit finished = 0;

  // Bench model state: instance 0 small/AND, 1 middle/OR, 2 large/AND
  logic [3:0]  mR [3][8];
  logic [15:0] mD [3];
  logic        eErr [3];
  logic [3:0]  eIdx [3];
  logic        eWr [3];
  logic        eOnD [3];
  string       rTag [3];

  function automatic bit isCmos(int i); return (i != 1); endfunction

  function automatic bit wrAccepted(int v, int idx);
    if (v == 0) return (idx >= 1 && idx <= 3);
    if (v == 1) return (idx <= 5);
    return (idx != 7);
  endfunction

  function automatic bit rdIllegal(int v, int idx);
    if (v == 0) return (idx >= 2);
    return (idx >= 6);
  endfunction

  function automatic bit lineOutOnly(int v, int idx);
    return (v == 0) && (idx >= 4);
  endfunction

  function automatic logic [31:0] packR(int i);
    logic [31:0] w;
    for (int p = 0; p < 8; p++) w[p*4 +: 4] = mR[i][p];
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Registered outputs, sampled at the falling edge after the taking edge
  task automatic checkRegs();
    for (int i = 0; i < 3; i++) begin
      chk(rPO[i] === packR(i), rTag[i], $sformatf("rPinOut inst%0d", i), rPO[i], packR(i));
      chk(dPO[i] === mD[i], "R5", $sformatf("dPinOut inst%0d", i), dPO[i], mD[i]);
      chk(ae[i] === eErr[i], "R10", $sformatf("accErr inst%0d", i), ae[i], eErr[i]);
      if (eErr[i]) begin
        chk({aeI[i], aeW[i], aeD[i]} === {eIdx[i], eWr[i], eOnD[i]}, "R10",
            $sformatf("err fields inst%0d", i), {aeI[i], aeW[i], aeD[i]},
            {eIdx[i], eWr[i], eOnD[i]});
      end
    end
  endtask

  task automatic step(input logic rWe, input logic [7:0] rWi, input logic [7:0] rWd,
                      input logic rRe, input logic [7:0] rRi,
                      input logic dWe, input logic [7:0] dWi, input logic dWv,
                      input logic dRe, input logic [7:0] dRi,
                      input logic [31:0] pinR, input logic [7:0] drv, input logic [15:0] pinD);
    int rw, rr, dw, dr;
    @(negedge clk);
    checkRegs();
    rWrEn = rWe; rWrIdx = rWi; rWrData = rWd; rRdEn = rRe; rRdIdx = rRi;
    dWrEn = dWe; dWrIdx = dWi; dWrVal = dWv; dRdEn = dRe; dRdIdx = dRi;
    rPinIn = pinR; rPinDriven = drv; dPinIn = pinD;
    rw = int'(rWi[2:0]); rr = int'(rRi[2:0]); dw = int'(dWi[3:0]); dr = int'(dRi[3:0]);
    #1;
    for (int i = 0; i < 3; i++) begin
      logic [3:0] inN, expN;
      logic expB;
      inN  = drv[rr] ? pinR[rr*4 +: 4] : 4'hF;
      expN = isCmos(i) ? (inN & mR[i][rr]) : (inN | mR[i][rr]);
      chk(rRD[i] === expN, drv[rr] ? "R3" : "R4", $sformatf("rRdData inst%0d idx%0d", i, rr),
          rRD[i], expN);
      if (lineOutOnly(i, dr)) expB = mD[i][dr];
      else expB = isCmos(i) ? (pinD[dr] & mD[i][dr]) : (pinD[dr] | mD[i][dr]);
      chk(dRB[i] === expB, lineOutOnly(i, dr) ? "R7" : "R6",
          $sformatf("dRdBit inst%0d idx%0d", i, dr), dRB[i], expB);
      // model update for the coming edge
      rTag[i] = "R2";
      eErr[i] = 1'b0; eIdx[i] = 4'd0; eWr[i] = 1'b0; eOnD[i] = 1'b0;
      if (rWe && !wrAccepted(i, rw)) begin
        rTag[i] = (i == 0) ? "R7" : (i == 1) ? "R8" : "R9";
        eErr[i] = 1'b1; eIdx[i] = 4'(rw); eWr[i] = 1'b1;
      end else if (rRe && rdIllegal(i, rr)) begin
        eErr[i] = 1'b1; eIdx[i] = 4'(rr);
      end else if (dRe && lineOutOnly(i, dr)) begin
        eErr[i] = 1'b1; eIdx[i] = 4'(dr); eOnD[i] = 1'b1;
      end
      if (rWe && wrAccepted(i, rw)) mR[i][rw] = rWd[3:0];
      if (dWe) mD[i][dw] = dWv;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    for (int i = 0; i < 3; i++) begin
      for (int p = 0; p < 8; p++) mR[i][p] = 4'hF;
      mD[i] = 16'hFFFF;
      eErr[i] = 0; eIdx[i] = 0; eWr[i] = 0; eOnD[i] = 0;
      rTag[i] = "R1";
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    checkRegs();
    rst = 1'b0;
    for (int i = 0; i < 3; i++) rTag[i] = "R2";

    // R7/R8: write to nibble port 0 (ignored on small only)
    step(1, 8'h00, 8'h35, 0, 8'h00, 0, 8'h00, 0, 0, 8'h00, 32'h0, 8'hFF, 16'h0);
    // R2: truncated index 0xFB -> 3, high data bits dropped
    step(1, 8'hFB, 8'hA6, 1, 8'h00, 0, 8'h00, 0, 0, 8'h00, 32'hFFFF_FFFF, 8'hFF, 16'h0);
    // R9: index 7 ignored everywhere
    step(1, 8'h07, 8'h00, 1, 8'h03, 0, 8'h00, 0, 0, 8'h00, 32'h5A5A_5A5A, 8'hFF, 16'h0);
    // R8: index 6 ignored on middle, taken on large
    step(1, 8'h06, 8'h02, 0, 8'h03, 0, 8'h00, 0, 0, 8'h00, 32'h0, 8'h00, 16'h0);
    // R8: index 4 storage on middle, ignored on small
    step(1, 8'h04, 8'h09, 1, 8'h04, 0, 8'h00, 0, 0, 8'h00, 32'h0, 8'h00, 16'h0);
    // R4: undriven read of port 4
    step(0, 8'h00, 8'h00, 1, 8'h04, 0, 8'h00, 0, 0, 8'h00, 32'h0, 8'h00, 16'h0);
    // R5: line index 0x25 -> 5 cleared
    step(0, 8'h00, 8'h00, 0, 8'h01, 1, 8'h25, 0, 0, 8'h05, 32'h0, 8'hFF, 16'hFFFF);
    // R7: latch-only read of line 5 with pins high, error on small
    step(0, 8'h00, 8'h00, 0, 8'h01, 0, 8'h00, 0, 1, 8'h05, 32'h0, 8'hFF, 16'hFFFF);
    // R10: nibble read and line read errors together, nibble read wins
    step(0, 8'h00, 8'h00, 1, 8'h06, 0, 8'h00, 0, 1, 8'h09, 32'h0, 8'hFF, 16'h0);
    // R10: write and read errors together, write wins
    step(1, 8'h07, 8'h01, 1, 8'h07, 1, 8'h13, 0, 1, 8'h0C, 32'h0, 8'h0F, 16'h1234);

    for (int n = 0; n < 4000; n++) begin
      step($urandom_range(0, 1), 8'($urandom), 8'($urandom),
           $urandom_range(0, 1), 8'($urandom),
           $urandom_range(0, 1), 8'($urandom), 1'($urandom),
           $urandom_range(0, 1), 8'($urandom),
           $urandom, 8'($urandom), 16'($urandom));
    end
    @(negedge clk);
    checkRegs();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule